// File: doc/BRIEF.md
# UART Interrupt Status and Line Router

This block gathers the eleven interrupt causes of a serial port into one raw status word. Each cause sits at a fixed bit. A programmable enable word masks the causes. Six interrupt wires are then driven from fixed groups of the masked bits: one combined wire, plus separate wires for receive, transmit, receive timeout, modem status and line errors.

Neighbouring logic reports causes in two ways. A one-cycle set pulse latches a bit until software clears it. A level input keeps its bit set for as long as the level is high. The events themselves are produced elsewhere: FIFO thresholds, frame checks and timeout counters are all outside this block.

Software reaches the block through a small register port. A 2-bit select chooses one of four registers, with a write strobe, a write word and a combinational read word. The four registers are the raw status, the masked status, the enable word and a write-one-to-clear register. All six interrupt wires are registered, so each one follows its cause one clock later.

Top module: `uart_irq_router`

## Requirements
- R1: While reset is asserted and right after it is released, the raw status, the enable word and all six interrupt outputs are zero.
- R2: Raw status bit positions are: ring indicator 0, clear-to-send 1, carrier detect 2, data-set-ready 3, receive 4, transmit 5, receive timeout 6, framing error 7, parity error 8, break 9, overrun 10. A set pulse on cause k sets raw bit k at the next clock edge, where it stays until cleared. A high level on cause k keeps raw bit k at 1.
- R3: Select 2 reads and writes the 11-bit enable word. Select 1 reads the raw status ANDed with the enable word. Select 0 reads the raw status.
- R4: The error output is the OR of masked bits 7 to 10. The modem output is the OR of masked bits 0 to 3.
- R5: The receive, transmit and timeout outputs follow only masked bits 4, 5 and 6 respectively. The combined output is the OR of all eleven masked bits.
- R6: A write to select 3 clears every raw bit whose written bit is 1 and leaves every raw bit whose written bit is 0 unchanged. Select 3 reads as zero.
- R7: When a set pulse or a set level and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: Each output reflects the raw status and enable word one clock after they change. A cause latched at edge N shows on its line after edge N+1.
- R9: Read bits 31 to 11 are always zero and written bits 31 to 11 have no effect. Writes to select 0 or select 1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 11 | One-cycle set pulses, one per cause bit |
| src_level | input | 11 | Level causes, each holding its bit set while high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Register select: 0 raw, 1 masked, 2 enable, 3 clear |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word for the selected register |
| irq_any | output | 1 | Combined interrupt |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |
| irq_rto | output | 1 | Receive timeout interrupt |
| irq_modem | output | 1 | Modem status interrupt |
| irq_err | output | 1 | Line error interrupt |

## Verification
The assertions check several behaviours on every cycle:
- a set always beats a clear on the same bit;
- bits written as zero in the clear word stay intact, and bits written as one and not being set do clear;
- the enable word changes only on its own write;
- the error and modem wires follow the previous cycle's masked groups;
- the combined wire covers the other five;
- the upper read bits stay zero.

Only the bench scenarios can show a few other points:
- each cause lands at its documented position;
- each single-bit line routes correctly;
- an output lags its cause by exactly one clock;
- level causes survive a clear;
- stray writes to the read-only selects are ignored.

A cycle-by-cycle model also compares every output under a long pseudo-random mix of pulses, levels and register accesses.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int unsigned NUM_SRC  = 11;
  localparam int unsigned NUM_LINE = 6;

  // cause bit positions (decoded by software)
  localparam int unsigned B_RI  = 0;
  localparam int unsigned B_CTS = 1;
  localparam int unsigned B_DCD = 2;
  localparam int unsigned B_DSR = 3;
  localparam int unsigned B_RX  = 4;
  localparam int unsigned B_TX  = 5;
  localparam int unsigned B_RTO = 6;
  localparam int unsigned B_FE  = 7;
  localparam int unsigned B_PE  = 8;
  localparam int unsigned B_BE  = 9;
  localparam int unsigned B_OE  = 10;

  // output line indices
  localparam int unsigned L_ANY   = 0;
  localparam int unsigned L_RX    = 1;
  localparam int unsigned L_TX    = 2;
  localparam int unsigned L_RTO   = 3;
  localparam int unsigned L_MODEM = 4;
  localparam int unsigned L_ERR   = 5;

  typedef enum logic [1:0] {
    SEL_RAW    = 2'd0,
    SEL_MASKED = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_CLEAR  = 2'd3
  } reg_sel_e;

  typedef logic [NUM_SRC-1:0] cause_t;

  // group of cause bits feeding a given output line
  function automatic cause_t line_group(int unsigned line);
    cause_t g;
    g = '0;
    case (line)
      L_ANY:   g = '1;
      L_RX:    g[B_RX] = 1'b1;
      L_TX:    g[B_TX] = 1'b1;
      L_RTO:   g[B_RTO] = 1'b1;
      L_MODEM: begin
        g[B_RI] = 1'b1; g[B_CTS] = 1'b1; g[B_DCD] = 1'b1; g[B_DSR] = 1'b1;
      end
      L_ERR:   begin
        g[B_FE] = 1'b1; g[B_PE] = 1'b1; g[B_BE] = 1'b1; g[B_OE] = 1'b1;
      end
      default: g = '0;
    endcase
    return g;
  endfunction

  // next raw status: clear first, then sets win
  function automatic cause_t raw_update(cause_t raw, cause_t clr, cause_t set);
    return (raw & ~clr) | set;
  endfunction

endpackage

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t set_vec,
  input  cause_t clr_vec,
  input  logic   en_wr,
  input  cause_t en_wdata,
  output cause_t raw_q,
  output cause_t mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else begin
      raw_q <= raw_update(raw_q, clr_vec, set_vec);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (en_wr) begin
      mask_q <= en_wdata;
    end
  end

endmodule

// File: rtl/uart_irq_lines.sv
module uart_irq_lines
  import uart_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  cause_t              masked,
  output logic [NUM_LINE-1:0] line_q
);

  for (genvar li = 0; li < NUM_LINE; li++) begin : g_line
    logic hit;
    assign hit = |(masked & line_group(li));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_q[li] <= 1'b0;
      end else begin
        line_q[li] <= hit;
      end
    end
  end

endmodule

// File: rtl/uart_irq_router.sv
module uart_irq_router
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [10:0]       src_pulse,
  input  logic [10:0]       src_level,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_any,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rto,
  output logic              irq_modem,
  output logic              irq_err
);

  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  // named internal events, visible to the bound checker
  cause_t              set_vec;
  cause_t              clr_vec;
  logic                en_wr;
  cause_t              raw_q;
  cause_t              mask_q;
  cause_t              masked;
  cause_t              sel_word;
  logic [NUM_LINE-1:0] line_q;

  assign set_vec = src_pulse | src_level;
  assign clr_vec = (reg_wr && reg_sel == SEL_CLEAR) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign en_wr   = reg_wr && (reg_sel == SEL_ENABLE);
  assign masked  = raw_q & mask_q;

  uart_irq_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .en_wr    (en_wr),
    .en_wdata (reg_wdata[NUM_SRC-1:0]),
    .raw_q    (raw_q),
    .mask_q   (mask_q)
  );

  uart_irq_lines u_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .masked (masked),
    .line_q (line_q)
  );

  always_comb begin
    case (reg_sel)
      SEL_RAW:    sel_word = raw_q;
      SEL_MASKED: sel_word = masked;
      SEL_ENABLE: sel_word = mask_q;
      default:    sel_word = '0;
    endcase
  end

  assign reg_rdata = {{PAD_W{1'b0}}, sel_word};

  assign irq_any   = line_q[L_ANY];
  assign irq_rx    = line_q[L_RX];
  assign irq_tx    = line_q[L_TX];
  assign irq_rto   = line_q[L_RTO];
  assign irq_modem = line_q[L_MODEM];
  assign irq_err   = line_q[L_ERR];

endmodule

// File: rtl/uart_irq_router_chk.sv
module uart_irq_router_chk
  import uart_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input cause_t            set_vec,
  input cause_t            clr_vec,
  input logic              en_wr,
  input cause_t            raw_q,
  input cause_t            mask_q,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_any,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              irq_rto,
  input logic              irq_modem,
  input logic              irq_err
);

  localparam cause_t ERR_BITS   = 11'h780;
  localparam cause_t MODEM_BITS = 11'h00F;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (raw_q == '0 && mask_q == '0); // R1
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec))); // R7

  AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(raw_q & ~clr_vec)) == $past(raw_q & ~clr_vec))); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0)); // R6

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(mask_q)); // R3

  AST_ERR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_err == |($past(raw_q & mask_q) & ERR_BITS))); // R4

  AST_MODEM_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_modem == |($past(raw_q & mask_q) & MODEM_BITS))); // R4

  AST_ANY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any == (irq_rx | irq_tx | irq_rto | irq_modem | irq_err)); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NUM_SRC] == '0); // R9

endmodule

bind uart_irq_router uart_irq_router_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .en_wr     (en_wr),
  .raw_q     (raw_q),
  .mask_q    (mask_q),
  .reg_rdata (reg_rdata),
  .irq_any   (irq_any),
  .irq_rx    (irq_rx),
  .irq_tx    (irq_tx),
  .irq_rto   (irq_rto),
  .irq_modem (irq_modem),
  .irq_err   (irq_err)
);

// File: tb/uart_irq_router_test.sv
module uart_irq_router_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] src_pulse = '0;
  logic [10:0] src_level = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_any, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

  always #10 clk = ~clk;

  uart_irq_router uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .src_level(src_level),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rto(irq_rto),
    .irq_modem(irq_modem), .irq_err(irq_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference state
  bit [10:0] raw_m  = '0;
  bit [10:0] mask_m = '0;
  bit [5:0]  out_m  = '0; // {err, modem, rto, tx, rx, any}

  function automatic bit [5:0] lines_of(bit [10:0] m);
    bit [5:0] r = '0;
    for (int k = 0; k < 11; k++) begin
      if (m[k]) begin
        r[0] = 1;
        if (k < 4)  r[4] = 1;
        if (k == 4) r[1] = 1;
        if (k == 5) r[2] = 1;
        if (k == 6) r[3] = 1;
        if (k > 6)  r[5] = 1;
      end
    end
    return r;
  endfunction

  function automatic bit [31:0] read_of(bit [1:0] s);
    case (s)
      2'd0: return {21'd0, raw_m};
      2'd1: return {21'd0, raw_m & mask_m};
      2'd2: return {21'd0, mask_m};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R5", "irq_any", irq_any, out_m[0]);
    check("R5", "irq_rx", irq_rx, out_m[1]);
    check("R5", "irq_tx", irq_tx, out_m[2]);
    check("R5", "irq_rto", irq_rto, out_m[3]);
    check("R4", "irq_modem", irq_modem, out_m[4]);
    check("R4", "irq_err", irq_err, out_m[5]);
    check("R3", "reg_rdata", reg_rdata, read_of(reg_sel));
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit [10:0] p, bit [10:0] l, bit w, bit [1:0] s, bit [31:0] d);
    src_pulse = p; src_level = l; reg_wr = w; reg_sel = s; reg_wdata = d;
    @(posedge clk);
    out_m = lines_of(raw_m & mask_m);
    if (w && s == 2'd3) raw_m = raw_m & ~d[10:0];
    raw_m = raw_m | p | l;
    if (w && s == 2'd2) mask_m = d[10:0];
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(bit [1:0] s);
    step('0, '0, 1'b0, s, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int s = 0; s < 3; s++) begin
      reg_sel = s[1:0]; #1;
      check("R1", "rdata in reset", reg_rdata, 0);
    end
    check("R1", "irq_any in reset", irq_any, 0);
    rst_n = 1'b1;
    idle(2'd2);
    check("R1", "enable after reset", reg_rdata, 0);
    check("R1", "irq_err after reset", irq_err, 0);

    // enable all causes
    step('0, '0, 1'b1, 2'd2, 32'h0000_07FF);
    check("R3", "enable readback", reg_rdata, 32'h7FF);

    // R2 / R8: each cause at its position and its routing
    for (int k = 0; k < 11; k++) begin
      step(11'(1 << k), '0, 1'b0, 2'd0, 0);
      check("R2", "raw bit position", reg_rdata, 32'(1 << k));
      check("R8", "line not yet high", irq_any, 0);
      idle(2'd1);
      check("R8", "irq_any one clock later", irq_any, 1);
      check("R5", "irq_rx routing", irq_rx, k == 4);
      check("R5", "irq_tx routing", irq_tx, k == 5);
      check("R5", "irq_rto routing", irq_rto, k == 6);
      check("R4", "irq_modem routing", irq_modem, k < 4);
      check("R4", "irq_err routing", irq_err, k > 6);
      step('0, '0, 1'b1, 2'd3, 32'hFFFF_FFFF);
      check("R6", "clear reads zero", reg_rdata, 0);
    end

    // R6: selective clear keeps zero-written bits
    step(11'h5A5, '0, 1'b0, 2'd0, 0);
    step('0, '0, 1'b1, 2'd3, 32'h0000_0105);
    reg_sel = 2'd0; #1;
    check("R6", "partial clear", reg_rdata, 32'h4A0);
    step('0, '0, 1'b1, 2'd3, 32'h0000_07FF);

    // R7: set beats clear on the same bit
    step(11'h200, '0, 1'b1, 2'd3, 32'h0000_07FF);
    idle(2'd0);
    check("R7", "set wins over clear", reg_rdata, 32'h200);
    // level cause held against a clear
    step('0, 11'h002, 1'b1, 2'd3, 32'h0000_07FF);
    step('0, 11'h002, 1'b1, 2'd3, 32'h0000_07FF);
    reg_sel = 2'd0; #1;
    check("R2", "level holds bit", reg_rdata, 32'h002);
    step('0, '0, 1'b1, 2'd3, 32'h0000_07FF);
    idle(2'd0);
    check("R6", "level released then cleared", reg_rdata, 0);

    // R3: mask subset gates lines
    step('0, '0, 1'b1, 2'd2, 32'h0000_0010);
    step(11'h7FF, '0, 1'b0, 2'd1, 0);
    check("R3", "masked read", reg_rdata, 32'h010);
    idle(2'd1);
    check("R5", "only rx enabled", {irq_err, irq_modem, irq_rto, irq_tx, irq_rx, irq_any}, 6'b000011);

    // R9: upper bits and read-only selects
    step('0, '0, 1'b1, 2'd2, 32'hFFFF_F800);
    check("R9", "upper enable bits dropped", reg_rdata, 0);
    step('0, '0, 1'b1, 2'd0, 32'h0000_0000);
    check("R9", "raw write ignored", reg_rdata, 32'h7FF);
    step('0, '0, 1'b1, 2'd1, 32'h0000_0000);
    reg_sel = 2'd0; #1;
    check("R9", "masked write ignored", reg_rdata, 32'h7FF);
    step('0, '0, 1'b1, 2'd3, 32'hFFFF_F800);
    reg_sel = 2'd0; #1;
    check("R9", "upper clear bits no effect", reg_rdata, 32'h7FF);

    // pseudo-random mix against the model
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[10:0] & lfsr[21:11],
           (lfsr[31:29] == 3'd0) ? (lfsr[10:0] & lfsr[20:10] & lfsr[30:20]) : 11'd0,
           lfsr[3], lfsr[5:4], lfsr ^ {lfsr[15:0], lfsr[31:16]});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule